// File: doc/BRIEF.md
# ECC Syndrome Compare and Classifier

This block sits on the read path of a NAND-style sector ECC engine. It takes two 24-bit parity words for one 512-byte sector. One is the parity computed over the data just read. The other is the parity that was stored in the page's spare area. Their XOR forms a syndrome, and the block sorts that syndrome into one of four outcomes:

- clean data;
- a single flipped data bit, which can be corrected;
- a corrupted stored code, where the data itself is fine;
- damage that cannot be corrected.

The parity word holds twelve odd/even pairs. Bits [23:12] are the odd-parity bits, from the most significant pair (bit 23) down to the least significant pair (bit 12). Bits [11:0] are the matching even-parity bits in the same order, so bit `12+i` pairs with bit `i`. When the data is correctable, the block also reports where the flipped bit is: a 9-bit byte address and a 3-bit bit index. A sector-buffer fixer can use these to flip that bit back.

Each input is accepted with a valid/ready handshake. The result is registered and offered on a valid/ready output one cycle after acceptance. The output register frees up in the same cycle it is drained, so the block can take one sector every cycle.

Top module: `ecc_syndrome_classifier`

## Requirements
- R1: The syndrome is `calcParity ^ storedParity`. The classification depends only on that syndrome, not on either parity word alone.
- R2: An all-zero syndrome gives status 2'b00 (no error).
- R3: If every pair disagrees (syndrome bit `12+i` differs from bit `i` for all i in 0..11), the status is 2'b01 (corrected single bit). In that case `errByte` = syndrome[23:15] and `errBit` = syndrome[14:12].
- R4: A syndrome with exactly one bit set gives status 2'b10 (stored code corrupt, data good).
- R5: Any other non-zero syndrome gives status 2'b11 (uncorrectable).
- R6: Whenever the presented status is not 2'b01, `errByte` and `errBit` are zero.
- R7: An input is accepted on a clock edge where `inValid` and `inReady` are both high. Its result appears with `outValid` high after that edge. `inReady` equals `!outValid || outReady`. While `outValid` is high and `outReady` is low, the status and location outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Parity pair presented |
| inReady | output | 1 | Block can accept a parity pair |
| calcParity | input | 24 | Parity computed over the read data |
| storedParity | input | 24 | Parity read from the spare area |
| outValid | output | 1 | Result registered and available |
| outReady | input | 1 | Consumer takes the result |
| status | output | 2 | 00 clean, 01 corrected, 10 code error, 11 uncorrectable |
| errByte | output | 9 | Byte address of the flipped bit (status 01 only) |
| errBit | output | 3 | Bit index within the byte (status 01 only) |

## Verification
The block keeps only a valid flag and one result register, so any fault inside it shows up on the very next output cycle:

- a wrong classification shows as a wrong status code;
- a mis-sliced location shows as a wrong byte or bit index;
- a bad valid flag shows as a dropped or duplicated `outValid`, or as a wrong `inReady`.

The bench compares every cycle against a model. It sweeps all 4096 correctable positions, all 24 single code-bit faults, random double-bit faults and random patterns, and it inserts output stalls. Each of these faults is therefore caught within one cycle of the input that triggers it.

// File: rtl/ecc_cmp_pkg.sv
package ecc_cmp_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'b00,
    ST_FIXED    = 2'b01,
    ST_CODE_ERR = 2'b10,
    ST_UNCORR   = 2'b11
  } eccStatus_t;

  typedef struct packed {
    logic capture;  // load a new result into the output register
    logic retire;   // output consumed and nothing new loaded
  } eccStrobe_t;

endpackage

// File: rtl/ecc_cmp_ctrl.sv
module ecc_cmp_ctrl
  import ecc_cmp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output eccStrobe_t strobe
);

  logic validQ;

  assign inReady        = !validQ || outReady;
  assign strobe.capture = inValid && inReady;
  assign strobe.retire  = validQ && outReady && !strobe.capture;
  assign outValid       = validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (strobe.capture) begin
      validQ <= 1'b1;
    end else if (strobe.retire) begin
      validQ <= 1'b0;
    end
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);  // R7

  AST_ACCEPT_RAISES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid);  // R7

endmodule

// File: rtl/ecc_cmp_datapath.sv
module ecc_cmp_datapath
  import ecc_cmp_pkg::*;
#(
  parameter int PAIRS     = 12,
  parameter int BIT_IDX_W = 3,
  localparam int PAR_W    = 2 * PAIRS,
  localparam int ADDR_W   = PAIRS - BIT_IDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  eccStrobe_t           strobe,
  input  logic [PAR_W-1:0]     calcParity,
  input  logic [PAR_W-1:0]     storedParity,
  output eccStatus_t           statusQ,
  output logic [ADDR_W-1:0]    byteQ,
  output logic [BIT_IDX_W-1:0] bitQ
);

  localparam int CNT_W = $clog2(PAR_W + 1);

  logic [PAR_W-1:0]  syndrome;
  logic [PAIRS-1:0]  pairSplit;
  logic [PAIRS-1:0]  oddHalf;
  logic [CNT_W-1:0]  onesCount;
  logic              allSplit;
  logic              isZero;
  logic              singleHot;
  eccStatus_t        classNext;

  assign syndrome = calcParity ^ storedParity;
  assign oddHalf  = syndrome[PAR_W-1:PAIRS];

  // Odd and even member of each pair disagree for a single data-bit flip.
  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    assign pairSplit[i] = syndrome[PAIRS+i] ^ syndrome[i];
  end

  always_comb begin
    onesCount = '0;
    for (int k = 0; k < PAR_W; k++) begin
      onesCount = onesCount + CNT_W'(syndrome[k]);
    end
  end

  assign allSplit  = &pairSplit;
  assign isZero    = ~|syndrome;
  assign singleHot = (onesCount == CNT_W'(1));

  always_comb begin
    if (isZero)         classNext = ST_CLEAN;
    else if (allSplit)  classNext = ST_FIXED;
    else if (singleHot) classNext = ST_CODE_ERR;
    else                classNext = ST_UNCORR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= ST_CLEAN;
      byteQ   <= '0;
      bitQ    <= '0;
    end else if (strobe.capture) begin
      statusQ <= classNext;
      if (classNext == ST_FIXED) begin
        byteQ <= oddHalf[PAIRS-1:BIT_IDX_W];
        bitQ  <= oddHalf[BIT_IDX_W-1:0];
      end else begin
        byteQ <= '0;
        bitQ  <= '0;
      end
    end
  end

  AST_CLEAN_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && (calcParity == storedParity) |=> statusQ == ST_CLEAN);  // R2

  AST_CODE_BIT_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && ($countones(calcParity ^ storedParity) == 1)
      |=> statusQ == ST_CODE_ERR);  // R4

  AST_LOC_ONLY_WHEN_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    statusQ != ST_FIXED |-> (byteQ == '0) && (bitQ == '0));  // R6

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(statusQ) && $stable(byteQ) && $stable(bitQ));  // R7

endmodule

// File: rtl/ecc_syndrome_classifier.sv
module ecc_syndrome_classifier
  import ecc_cmp_pkg::*;
#(
  parameter int PAIRS     = 12,
  parameter int BIT_IDX_W = 3,
  localparam int PAR_W    = 2 * PAIRS,
  localparam int ADDR_W   = PAIRS - BIT_IDX_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [PAR_W-1:0]     calcParity,
  input  logic [PAR_W-1:0]     storedParity,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [1:0]           status,
  output logic [ADDR_W-1:0]    errByte,
  output logic [BIT_IDX_W-1:0] errBit
);

  eccStrobe_t strobe;
  eccStatus_t statusQ;

  ecc_cmp_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  ecc_cmp_datapath #(
    .PAIRS     (PAIRS),
    .BIT_IDX_W (BIT_IDX_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .calcParity   (calcParity),
    .storedParity (storedParity),
    .statusQ      (statusQ),
    .byteQ        (errByte),
    .bitQ         (errBit)
  );

  assign status = statusQ;

endmodule

// File: tb/ecc_syndrome_classifier_test.sv
`timescale 1ns/1ps
module ecc_syndrome_classifier_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [23:0] calcParity = '0;
  logic [23:0] storedParity = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [1:0]  status;
  logic [8:0]  errByte;
  logic [2:0]  errBit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  bit       mValid = 1'b0;
  bit [1:0] mStatus = 2'b00;
  bit [8:0] mByte = '0;
  bit [2:0] mBit = '0;

  always #5 clk = ~clk;

  ecc_syndrome_classifier uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .calcParity(calcParity), .storedParity(storedParity),
    .outValid(outValid), .outReady(outReady),
    .status(status), .errByte(errByte), .errBit(errBit)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural classification written from the requirements.
  function automatic void refClassify(input bit [23:0] syn, output bit [1:0] st,
                                      output bit [8:0] by, output bit [2:0] bi);
    int ones = 0;
    int splits = 0;
    for (int k = 0; k < 24; k++) ones += syn[k];
    for (int p = 0; p < 12; p++) if (syn[12+p] != syn[p]) splits++;
    by = '0; bi = '0;
    if (ones == 0) st = 2'b00;
    else if (splits == 12) begin
      st = 2'b01; by = syn[23:15]; bi = syn[14:12];
    end else if (ones == 1) st = 2'b10;
    else st = 2'b11;
  endfunction

  function automatic string tagFor(input bit [1:0] st);
    case (st)
      2'b00: return "R2";
      2'b01: return "R1/R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic step(input bit v, input bit [23:0] c, input bit [23:0] s, input bit r);
    bit acc;
    bit [1:0] st;
    bit [8:0] by;
    bit [2:0] bi;
    @(negedge clk);
    inValid = v; calcParity = c; storedParity = s; outReady = r;
    #1;
    check(inReady == (!mValid || r), "R7", "inReady", inReady, (!mValid || r));
    acc = v && inReady;
    @(posedge clk);
    if (acc) begin
      refClassify(c ^ s, st, by, bi);
      mValid = 1'b1; mStatus = st; mByte = by; mBit = bi;
    end else if (r) begin
      mValid = 1'b0;
    end
    #2;
    check(outValid == mValid, "R7", "outValid", outValid, mValid);
    if (mValid) begin
      check(status == mStatus, tagFor(mStatus), "status", status, mStatus);
      if (mStatus == 2'b01) begin
        check(errByte == mByte, "R3", "errByte", errByte, mByte);
        check(errBit == mBit, "R3", "errBit", errBit, mBit);
      end else begin
        check(errByte == 0 && errBit == 0, "R6", "location",
              {errByte, errBit}, 0);
      end
    end
  endtask

  initial begin
    #(10ns * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit [23:0] base;
    repeat (3) @(posedge clk);
    #2;
    check(outValid == 1'b0, "R7", "reset outValid", outValid, 0);
    check(inReady == 1'b1, "R7", "reset inReady", inReady, 1);
    check(status == 2'b00 && errByte == 0 && errBit == 0, "R6", "reset outputs",
          {status, errByte, errBit}, 0);
    @(negedge clk); rstN = 1'b1;

    // R2: matching parity, several bases
    step(1, 24'h000000, 24'h000000, 1);
    step(1, 24'hA5C3F0, 24'hA5C3F0, 1);
    step(1, 24'hFFFFFF, 24'hFFFFFF, 1);

    // R3 with R1: every correctable position, random base parity
    for (int loc = 0; loc < 4096; loc++) begin
      base = 24'($urandom);
      step(1, base ^ {12'(loc), ~12'(loc)}, base, 1);
    end

    // R4: each single code bit flipped, in both operands
    for (int b = 0; b < 24; b++) begin
      base = 24'($urandom);
      step(1, base ^ (24'h1 << b), base, 1);
      step(1, base, base ^ (24'h1 << b), 1);
    end

    // R5: random double-bit faults
    for (int n = 0; n < 300; n++) begin
      int a = $urandom_range(0, 23);
      int b = $urandom_range(0, 23);
      if (a == b) b = (a + 1) % 24;
      base = 24'($urandom);
      step(1, base ^ (24'h1 << a) ^ (24'h1 << b), base, 1);
    end

    // Random patterns with back-pressure and idle cycles (R7)
    for (int n = 0; n < 2000; n++) begin
      step(($urandom % 4) != 0, 24'($urandom), 24'($urandom), ($urandom % 3) != 0);
    end

    // Explicit stall: result must hold while outReady low (R7)
    step(1, 24'h800FFF ^ 24'h123456, 24'h123456, 0);
    step(1, 24'h000001, 24'h000000, 0);
    step(0, 24'h0, 24'h0, 0);
    step(0, 24'h0, 24'h0, 1);
    step(0, 24'h0, 24'h0, 1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule